// File: doc/BRIEF.md
# Two-Wire Slave Command Decoder

This block is the serial front end of a two-wire slave. It samples the clock and data lines on a fast system clock and detects START and STOP conditions. It then frames the first two bytes of every command. The first byte identifies the device. Its upper nibble must carry a fixed type code, and its lower nibble must match four pin-strapped address inputs. The slave acknowledges that byte only when both nibbles match. The second byte is split into an opcode, a data-register index and a wiper select. These fields are presented on a parallel output together with a single-cycle strobe.

Some opcodes are marked by a parameter mask as nonvolatile writes. When a STOP closes one of these commands, the block starts an internal busy timer. While the timer runs, the slave refuses to acknowledge its own address. A host can therefore poll with START plus address until an acknowledge comes back, and then go on with the next command. Data-byte phases and the storage itself sit outside this block.

Top module: `tw_cmd_decoder`

## Requirements
- R1: After reset, the SDA output enable is released (`sda_oe_n_o` high), `cmd_valid_o` is low and `busy_o` is low.
- R2: A START seen at any point restarts byte framing, so a command sent after a START that cut into a partial byte is decoded normally.
- R3: If bits [7:4] of the first byte are not 4'b0101, the slave does not acknowledge and produces no command strobe.
- R4: If bits [3:0] of the first byte differ from `addr_pins_i` in any bit, the slave does not acknowledge and produces no command strobe.
- R5: For an accepted byte, `sda_oe_n_o` is low during the high phase of the ninth SCL pulse, and it is released after that pulse falls.
- R6: The second byte is decoded as opcode = bits [7:3], register index = bits [2:1] (00 to 11 select registers 0 to 3) and wiper = bit [0].
- R7: After the second byte has been acknowledged, `cmd_valid_o` is high for exactly one system clock cycle, and the decoded fields are stable while it is high.
- R8: A STOP after a completed command whose opcode has its bit set in `NV_MASK` (default: opcodes 12 to 15) raises `busy_o` within a few cycles. `busy_o` then stays high for exactly `BUSY_CYCLES` cycles.
- R9: A STOP after a command whose opcode bit is clear in `NV_MASK` leaves `busy_o` low.
- R10: While `busy_o` is high, a matching address byte is not acknowledged and no command strobe appears.
- R11: Once `busy_o` has fallen, a matching address byte is acknowledged and a full command is decoded again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_pins_i | input | 4 | Pin-strapped device address |
| sda_oe_n_o | output | 1 | Active-low pull-down enable for SDA (low = acknowledge) |
| cmd_valid_o | output | 1 | One-cycle strobe for a decoded command |
| cmd_opcode_o | output | 5 | Decoded opcode |
| cmd_reg_o | output | 2 | Decoded data-register index |
| cmd_wiper_o | output | 1 | Decoded wiper select |
| busy_o | output | 1 | High while the internal write timer runs |

## Verification
The bench targets five situations:

- **Address rejection.** Bytes whose type nibble or address nibble is wrong must be rejected. A decoder that compared only one nibble would acknowledge them and strobe a stray command.
- **Restart mid-byte.** A START is issued part-way through a byte. A design that did not clear its bit counter on START would misalign the next bytes, and the acknowledges would fall on the wrong clocks.
- **Busy length.** The busy window is timed to the exact cycle. An off-by-one in the timer reload shows up as a wrong count.
- **Polling while busy.** A poll during the busy window must get no acknowledge. A design that ignored `busy_o` would acknowledge too early.
- **Mask handling.** A non-write opcode must leave the timer idle. A decoder that ignored the mask would start the timer anyway.

// File: rtl/tw_cmd_pkg.sv
package tw_cmd_pkg;
   localparam int BYTE_W = 8;
   localparam int OP_W   = 5;
   localparam int REG_W  = 2;
   localparam logic [3:0] DEV_TYPE = 4'b0101;

   typedef enum logic [2:0] {
      FR_IDLE,
      FR_ID,
      FR_ID_ACK,
      FR_INS,
      FR_INS_ACK,
      FR_DATA,
      FR_SKIP
   } fr_state_t;

   typedef struct packed {
      logic [OP_W-1:0]  op;
      logic [REG_W-1:0] reg_sel;
      logic             wiper;
   } cmd_t;
endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_smp
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("tw_line_sync: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic scl_q, sda_q;
   logic scl_s, sda_s;

   assign scl_s = scl_sh[SYNC_STAGES-1];
   assign sda_s = sda_sh[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         scl_q  <= scl_s;
         sda_q  <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
   assign sda_smp   = sda_s;
endmodule

// File: rtl/tw_busy_timer.sv
module tw_busy_timer #(
   parameter int BUSY_CYCLES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic busy
);
   localparam int CW = $clog2(BUSY_CYCLES + 1);

   generate
      if (BUSY_CYCLES < 1) begin : g_bad_len
         $error("tw_busy_timer: BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (arm && cnt == '0) begin
         cnt <= CW'(BUSY_CYCLES);
      end else if (cnt != '0) begin
         cnt <= cnt - CW'(1);
      end
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/tw_frame.sv
module tw_frame
   import tw_cmd_pkg::*;
#(
   parameter logic [2**OP_W-1:0] NV_MASK = 32'h0000_F000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_rise,
   input  logic            scl_fall,
   input  logic            start_det,
   input  logic            stop_det,
   input  logic            sda_smp,
   input  logic [3:0]      addr_pins,
   input  logic            busy,
   output logic            ack_drv,
   output logic            cmd_valid,
   output cmd_t            cmd,
   output logic            nv_arm,
   output fr_state_t       state_o
);
   fr_state_t         state;
   logic [3:0]        bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic              pend_nv;

   assign nv_arm  = stop_det & (state == FR_DATA) & pend_nv;
   assign state_o = state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= FR_IDLE;
         bit_cnt   <= '0;
         shreg     <= '0;
         pend_nv   <= 1'b0;
         ack_drv   <= 1'b0;
         cmd_valid <= 1'b0;
         cmd       <= '0;
      end else begin
         cmd_valid <= 1'b0;
         if (start_det) begin
            state   <= FR_ID;
            bit_cnt <= '0;
            ack_drv <= 1'b0;
            pend_nv <= 1'b0;
         end else if (stop_det) begin
            state   <= FR_IDLE;
            ack_drv <= 1'b0;
            pend_nv <= 1'b0;
         end else begin
            unique case (state)
               FR_ID, FR_INS: begin
                  if (scl_rise) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_smp};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'(BYTE_W)) begin
                     if (state == FR_ID) begin
                        if (shreg[7:4] == DEV_TYPE && shreg[3:0] == addr_pins && !busy) begin
                           ack_drv <= 1'b1;
                           state   <= FR_ID_ACK;
                        end else begin
                           state   <= FR_SKIP;
                        end
                     end else begin
                        ack_drv     <= 1'b1;
                        cmd.op      <= shreg[7:3];
                        cmd.reg_sel <= shreg[2:1];
                        cmd.wiper   <= shreg[0];
                        state       <= FR_INS_ACK;
                     end
                  end
               end
               FR_ID_ACK: begin
                  if (scl_fall) begin
                     ack_drv <= 1'b0;
                     bit_cnt <= '0;
                     state   <= FR_INS;
                  end
               end
               FR_INS_ACK: begin
                  if (scl_fall) begin
                     ack_drv   <= 1'b0;
                     cmd_valid <= 1'b1;
                     pend_nv   <= NV_MASK[cmd.op];
                     state     <= FR_DATA;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/tw_cmd_decoder.sv
module tw_cmd_decoder
   import tw_cmd_pkg::*;
#(
   parameter int                 SYNC_STAGES = 2,
   parameter int                 BUSY_CYCLES = 500000,
   parameter logic [2**OP_W-1:0] NV_MASK     = 32'h0000_F000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic [3:0]       addr_pins_i,
   output logic             sda_oe_n_o,
   output logic             cmd_valid_o,
   output logic [OP_W-1:0]  cmd_opcode_o,
   output logic [REG_W-1:0] cmd_reg_o,
   output logic             cmd_wiper_o,
   output logic             busy_o
);
   logic      scl_rise, scl_fall, start_det, stop_det, sda_smp;
   logic      ack_drv, nv_arm;
   cmd_t      cmd;
   fr_state_t fr_state;

   tw_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_smp(sda_smp)
   );

   tw_frame #(.NV_MASK(NV_MASK)) u_frame (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_smp(sda_smp),
      .addr_pins(addr_pins_i), .busy(busy_o), .ack_drv(ack_drv),
      .cmd_valid(cmd_valid_o), .cmd(cmd), .nv_arm(nv_arm), .state_o(fr_state)
   );

   tw_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .arm(nv_arm), .busy(busy_o)
   );

   assign sda_oe_n_o   = ~ack_drv;
   assign cmd_opcode_o = cmd.op;
   assign cmd_reg_o    = cmd.reg_sel;
   assign cmd_wiper_o  = cmd.wiper;
endmodule

// File: rtl/tw_cmd_decoder_chk.sv
module tw_cmd_decoder_chk
   import tw_cmd_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             busy_o,
   input logic             cmd_valid_o,
   input logic             sda_oe_n_o,
   input logic             stop_det,
   input fr_state_t        fr_state,
   input logic [OP_W-1:0]  cmd_opcode_o,
   input logic [REG_W-1:0] cmd_reg_o,
   input logic             cmd_wiper_o
);
   // R7: strobe lasts one cycle
   p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |=> !cmd_valid_o);

   // R6/R7: fields held steady across the strobe
   p_fields_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> ($stable(cmd_opcode_o) && $stable(cmd_reg_o) && $stable(cmd_wiper_o)));

   // R8: busy only starts right after a STOP
   p_busy_from_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_det));

   // R5: SDA released after a STOP
   p_release_on_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> sda_oe_n_o);

   // R10: no address acknowledge while busy
   p_no_ack_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (fr_state != FR_ID_ACK));

   // R10: no command strobe while busy
   p_no_strobe_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> !busy_o);
endmodule

bind tw_cmd_decoder tw_cmd_decoder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .cmd_valid_o(cmd_valid_o),
   .sda_oe_n_o(sda_oe_n_o), .stop_det(stop_det), .fr_state(fr_state),
   .cmd_opcode_o(cmd_opcode_o), .cmd_reg_o(cmd_reg_o), .cmd_wiper_o(cmd_wiper_o)
);

// File: tb/tw_cmd_decoder_tb_top.sv
module tw_cmd_decoder_tb_top;
   localparam int BUSY = 3000;
   localparam int Q    = 8;
   localparam logic [3:0] PINS = 4'b1010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_scl = 1'b1;
   logic host_sda = 1'b1;
   logic sda_line;
   logic sda_oe_n, cmd_valid, cmd_wiper, busy;
   logic [4:0] cmd_op;
   logic [1:0] cmd_reg;

   int n_tests = 0;
   int n_fail  = 0;
   int busy_total = 0;
   bit done = 0;
   bit prev_valid = 0;
   logic [7:0] exp_q[$];

   always #5 clk = ~clk;

   assign sda_line = host_sda & sda_oe_n;

   tw_cmd_decoder #(.BUSY_CYCLES(BUSY)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_line),
      .addr_pins_i(PINS), .sda_oe_n_o(sda_oe_n), .cmd_valid_o(cmd_valid),
      .cmd_opcode_o(cmd_op), .cmd_reg_o(cmd_reg), .cmd_wiper_o(cmd_wiper),
      .busy_o(busy)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic q;
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start;
      host_sda = 1'b1; q();
      host_scl = 1'b1; q();
      host_sda = 1'b0; q();
      host_scl = 1'b0; q();
   endtask

   task automatic bus_stop;
      host_sda = 1'b0; q();
      host_scl = 1'b1; q();
      host_sda = 1'b1; q();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         host_sda = b[i]; q();
         host_scl = 1'b1; q(); q();
         host_scl = 1'b0; q();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      send_bits(b, 8);
      host_sda = 1'b1; q();
      host_scl = 1'b1; q();
      acked = (sda_oe_n == 1'b0);
      q();
      host_scl = 1'b0; q();
   endtask

   // scoreboard monitor: R6 field compare, R7 pulse width
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (busy) busy_total++;
         if (cmd_valid) begin
            check(!prev_valid, "R7 strobe longer than one cycle", 1, 0);
            if (exp_q.size() == 0) begin
               check(1'b0, "R7 unexpected strobe", {cmd_op, cmd_reg, cmd_wiper}, -1);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               check({cmd_op, cmd_reg, cmd_wiper} == e, "R6 decoded fields",
                     {cmd_op, cmd_reg, cmd_wiper}, e);
            end
         end
         prev_valid = cmd_valid;
      end
   end

   task automatic full_cmd(input logic [7:0] ins, input string tag);
      bit a;
      bus_start();
      send_byte({4'b0101, PINS}, a);
      check(a, {tag, " address ack"}, a, 1);
      exp_q.push_back(ins);
      send_byte(ins, a);
      check(a, {tag, " instruction ack"}, a, 1);
      bus_stop();
   endtask

   initial begin
      repeat (100000) @(negedge clk);
      if (!done) begin
         done = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      bit a;
      repeat (3) @(negedge clk);
      check(sda_oe_n == 1'b1, "R1 oe released", sda_oe_n, 1);
      check(cmd_valid == 1'b0, "R1 valid low", cmd_valid, 0);
      check(busy == 1'b0, "R1 busy low", busy, 0);
      rst_n = 1'b1;
      q();

      // R5/R6/R9: plain command, opcode 9 reg 1 wiper 1
      full_cmd(8'h4B, "R5");
      repeat (50) @(negedge clk);
      check(busy == 1'b0, "R9 busy after non-write opcode", busy, 0);

      // R3: wrong type nibble
      bus_start();
      send_byte({4'b0110, PINS}, a);
      check(!a, "R3 wrong type nack", a, 0);
      send_byte(8'h62, a);
      bus_stop();

      // R4: wrong address nibble
      bus_start();
      send_byte({4'b0101, 4'b1011}, a);
      check(!a, "R4 wrong address nack", a, 0);
      send_byte(8'h4B, a);
      bus_stop();

      // R2: START cuts a partial byte
      bus_start();
      send_bits(8'h5A, 4);
      full_cmd(8'h16, "R2");

      // R8: write opcode 12 reg 1 wiper 0
      full_cmd(8'h62, "R8");
      check(busy == 1'b1, "R8 busy raised after stop", busy, 1);

      // R10: poll during busy
      bus_start();
      send_byte({4'b0101, PINS}, a);
      check(!a, "R10 nack while busy", a, 0);
      bus_stop();
      check(busy == 1'b1, "R10 still busy after poll", busy, 1);
      while (busy) @(negedge clk);
      check(busy_total == BUSY, "R8 busy length", busy_total, BUSY);

      // R11: accepted again after busy, opcode 15 reg 2 wiper 1
      full_cmd(8'h7D, "R11");
      while (busy) @(negedge clk);
      check(busy_total == 2 * BUSY, "R8 second busy length", busy_total, 2 * BUSY);

      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R7 all strobes seen", exp_q.size(), 0);

      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule